// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Unit

This block keeps the interrupt cause, status and sequence-step registers of a byte-wide SCSI host controller, and drives one level-sensitive interrupt line. Logic elsewhere in the controller signals events with one-cycle strobes: function complete, bus service, disconnect, bus reset and command completion. Each event sets its cause bit and requests the interrupt. The processor acknowledges by reading the interrupt cause register. That read returns the causes and clears the pending state in the same access.

A command completion that arrives while an interrupt is still unacknowledged is not lost. Its status byte is parked in a one-entry holding register. It is reported automatically on the read that acknowledges the earlier interrupt, so the line rises again right after that read. The same register port also gives access to the transfer-count bytes, the FIFO-flags byte and the configuration byte that the reporting sequence and the bus-reset event use.

Top module: `intr_status_unit`

## Requirements
- R1: A function-complete, bus-service or disconnect strobe sets cause bit 3, 4 or 5 of the cause register (address 9) and sets the pending flag, which is status bit 7 (address 8) and drives `irq` from the next cycle. A disconnect also zeroes the sequence step (address 10). A raise while already pending only adds its cause bit.
- R2: A read of address 9 returns the cause byte held before the read. In the same cycle it clears the cause register, clears status bit 4 (terminal count) and status bit 7, and loads the sequence step with 4. `irq` is low from the next cycle.
- R3: A raise strobe in the same cycle as a read of address 9 wins. `irq` stays high and the cause register then holds only the new cause.
- R4: A completion while not pending is reported at once. Status becomes 0x93 (phase value 3, terminal count, pending). The cause becomes 0x10. The sequence step, the FIFO flags (address 11) and all transfer-count bytes (addresses 0 to 2) become zero. The completion byte becomes readable at address 13.
- R5: A completion while pending changes neither the visible registers nor `irq`. Its status byte is held.
- R6: The read of address 9 that acknowledges a pending interrupt reports a held completion exactly as in R4, and consumes it. The following acknowledging read leaves `irq` low.
- R7: A second completion that arrives while one is already held replaces the held status byte.
- R8: A bus-reset strobe sets cause bit 7. It raises `irq` only when bit 6 of the configuration byte (address 12) is clear.
- R9: After reset every register reads zero except the configuration byte, which reads 7, and `irq` is low.
- R10: Writes load addresses 0 to 2, 11 and 12. A write to any transfer-count byte clears status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hard reset, active low |
| evFuncDone | input | 1 | Function-complete event strobe |
| evBusSvc | input | 1 | Bus-service event strobe |
| evDisc | input | 1 | Disconnect event strobe |
| evBusRst | input | 1 | Bus-reset event strobe |
| evCmpl | input | 1 | Command-completion strobe |
| cmplStatus | input | DATA_W | Status byte delivered with `evCmpl` |
| busAddr | input | ADDR_W | Register address |
| busWr | input | 1 | Register write strobe |
| busWrData | input | DATA_W | Register write data |
| busRd | input | 1 | Register read strobe |
| busRdData | output | DATA_W | Register read data, valid during the read cycle |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can fall in the same cycle: the acknowledging read of the cause register, and a new raise or completion. The bench drives a raise strobe together with the cause read. It requires the read to return only the old causes while the line stays high with just the new cause. It also issues the acknowledging read while a completion is held, and separately while a fresh completion arrives, and judges at the register port whether the completion is reported immediately or kept for the next read.

// File: rtl/isu_pkg.sv
package isu_pkg;

  localparam logic [3:0] A_STAT  = 4'd8;
  localparam logic [3:0] A_INTR  = 4'd9;
  localparam logic [3:0] A_SEQ   = 4'd10;
  localparam logic [3:0] A_FLAGS = 4'd11;
  localparam logic [3:0] A_CFG   = 4'd12;
  localparam logic [3:0] A_CSTAT = 4'd13;

  // status bit positions
  localparam int ST_TC  = 4;
  localparam int ST_INT = 7;
  localparam int PHASE_ST = 3;

  // cause bit positions
  localparam int IR_FC  = 3;
  localparam int IR_BS  = 4;
  localparam int IR_DC  = 5;
  localparam int IR_RST = 7;

  // configuration bit that suppresses the bus-reset interrupt
  localparam int CFG_RPT_DIS = 6;

  typedef struct packed {
    logic rdClr;
    logic rptDeferred;
    logic rptNow;
    logic holdCmpl;
    logic setFc;
    logic setBs;
    logic setDc;
    logic setRst;
    logic raiseRst;
  } ctrlStrobes_t;

endpackage

// File: rtl/isu_ctrl.sv
module isu_ctrl
  import isu_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evFuncDone,
  input  logic              evBusSvc,
  input  logic              evDisc,
  input  logic              evBusRst,
  input  logic              evCmpl,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              intPend,
  input  logic              cfgRptDis,
  output ctrlStrobes_t      strb
);

  logic defPend;
  logic rdIntr;
  logic intAfterRead;

  assign rdIntr = busRd && (busAddr == ADDR_W'(A_INTR));

  always_comb begin
    strb             = '0;
    strb.rdClr       = rdIntr;
    strb.rptDeferred = rdIntr && defPend;
    // pending state as seen once the read and any held report are applied
    intAfterRead     = strb.rptDeferred || (intPend && !rdIntr);
    strb.rptNow      = evCmpl && !intAfterRead;
    strb.holdCmpl    = evCmpl && intAfterRead;
    strb.setFc       = evFuncDone;
    strb.setBs       = evBusSvc;
    strb.setDc       = evDisc;
    strb.setRst      = evBusRst;
    strb.raiseRst    = evBusRst && !cfgRptDis;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      defPend <= 1'b0;
    end else if (strb.holdCmpl) begin
      defPend <= 1'b1;
    end else if (strb.rptDeferred) begin
      defPend <= 1'b0;
    end
  end

endmodule

// File: rtl/isu_dpath.sv
module isu_dpath
  import isu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int TC_BYTES = 3,
  parameter int CFG_INIT = 7,
  parameter int SEQ_DONE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] cmplStatus,
  output logic [DATA_W-1:0] busRdData,
  output logic              intPend,
  output logic              cfgRptDis
);

  logic [DATA_W-1:0] statR, statN;
  logic [DATA_W-1:0] intrR, intrN;
  logic [DATA_W-1:0] seqR, seqN;
  logic [DATA_W-1:0] flagsR, flagsN;
  logic [DATA_W-1:0] cfgR, cfgN;
  logic [DATA_W-1:0] heldR, heldN;
  logic [DATA_W-1:0] lastR, lastN;
  logic [DATA_W-1:0] tcR [TC_BYTES];
  logic              tcClr;
  logic              tcWrHit;
  logic              report;

  assign tcWrHit = busWr && (busAddr < ADDR_W'(TC_BYTES));
  assign report  = strb.rptDeferred || strb.rptNow;

  always_comb begin
    statN  = statR;
    intrN  = intrR;
    seqN   = seqR;
    flagsN = flagsR;
    cfgN   = cfgR;
    heldN  = heldR;
    lastN  = lastR;
    tcClr  = 1'b0;
    if (busWr && busAddr == ADDR_W'(A_FLAGS)) flagsN = busWrData;
    if (busWr && busAddr == ADDR_W'(A_CFG))   cfgN   = busWrData;
    if (tcWrHit) statN[ST_TC] = 1'b0;
    if (strb.rdClr) begin
      intrN         = '0;
      statN[ST_TC]  = 1'b0;
      statN[ST_INT] = 1'b0;
      seqN          = DATA_W'(SEQ_DONE);
    end
    if (report) begin
      statN         = DATA_W'(PHASE_ST);
      statN[ST_TC]  = 1'b1;
      statN[ST_INT] = 1'b1;
      intrN         = '0;
      intrN[IR_BS]  = 1'b1;
      seqN          = '0;
      flagsN        = '0;
      tcClr         = 1'b1;
      lastN         = strb.rptDeferred ? heldR : cmplStatus;
    end
    if (strb.setFc)  intrN[IR_FC]  = 1'b1;
    if (strb.setBs)  intrN[IR_BS]  = 1'b1;
    if (strb.setRst) intrN[IR_RST] = 1'b1;
    if (strb.setDc) begin
      intrN[IR_DC] = 1'b1;
      seqN         = '0;
    end
    if (strb.setFc || strb.setBs || strb.setDc || strb.raiseRst)
      statN[ST_INT] = 1'b1;
    if (strb.holdCmpl) heldN = cmplStatus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statR  <= '0;
      intrR  <= '0;
      seqR   <= '0;
      flagsR <= '0;
      cfgR   <= DATA_W'(CFG_INIT);
      heldR  <= '0;
      lastR  <= '0;
    end else begin
      statR  <= statN;
      intrR  <= intrN;
      seqR   <= seqN;
      flagsR <= flagsN;
      cfgR   <= cfgN;
      heldR  <= heldN;
      lastR  <= lastN;
    end
  end

  for (genvar g = 0; g < TC_BYTES; g++) begin : gTcByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tcR[g] <= '0;
      end else if (tcClr) begin
        tcR[g] <= '0;
      end else if (busWr && busAddr == ADDR_W'(g)) begin
        tcR[g] <= busWrData;
      end
    end
  end

  always_comb begin
    busRdData = '0;
    for (int i = 0; i < TC_BYTES; i++) begin
      if (busAddr == ADDR_W'(i)) busRdData = tcR[i];
    end
    case (busAddr)
      ADDR_W'(A_STAT):  busRdData = statR;
      ADDR_W'(A_INTR):  busRdData = intrR;
      ADDR_W'(A_SEQ):   busRdData = seqR;
      ADDR_W'(A_FLAGS): busRdData = flagsR;
      ADDR_W'(A_CFG):   busRdData = cfgR;
      ADDR_W'(A_CSTAT): busRdData = lastR;
      default: ;
    endcase
  end

  assign intPend   = statR[ST_INT];
  assign cfgRptDis = cfgR[CFG_RPT_DIS];

endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
  import isu_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int TC_BYTES = 3,
  parameter int CFG_INIT = 7,
  parameter int SEQ_DONE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evFuncDone,
  input  logic              evBusSvc,
  input  logic              evDisc,
  input  logic              evBusRst,
  input  logic              evCmpl,
  input  logic [DATA_W-1:0] cmplStatus,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);

  ctrlStrobes_t strb;
  logic         intPend;
  logic         cfgRptDis;

  isu_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .evFuncDone (evFuncDone),
    .evBusSvc   (evBusSvc),
    .evDisc     (evDisc),
    .evBusRst   (evBusRst),
    .evCmpl     (evCmpl),
    .busRd      (busRd),
    .busAddr    (busAddr),
    .intPend    (intPend),
    .cfgRptDis  (cfgRptDis),
    .strb       (strb)
  );

  isu_dpath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .TC_BYTES (TC_BYTES),
    .CFG_INIT (CFG_INIT),
    .SEQ_DONE (SEQ_DONE)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .cmplStatus (cmplStatus),
    .busRdData  (busRdData),
    .intPend    (intPend),
    .cfgRptDis  (cfgRptDis)
  );

  assign irq = intPend;

endmodule

// File: rtl/isu_checker.sv
module isu_checker
  import isu_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              evFuncDone,
  input logic              evBusSvc,
  input logic              evDisc,
  input logic              evBusRst,
  input logic              evCmpl,
  input logic              busRd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              irq,
  input logic              cfgRptDis,
  input ctrlStrobes_t      strb
);

  logic rdIntr;
  logic anyRaise;
  assign rdIntr   = busRd && (busAddr == ADDR_W'(A_INTR));
  assign anyRaise = evFuncDone || evBusSvc || evDisc;

  assert_raise_sets_irq_R1: assert property (@(posedge clk) disable iff (!rstN)
    anyRaise |=> irq);

  assert_read_lowers_irq_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdIntr && !anyRaise && !evBusRst && !evCmpl && !strb.rptDeferred) |=> !irq);

  assert_raise_beats_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdIntr && anyRaise) |=> irq);

  assert_held_keeps_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evCmpl && irq && !rdIntr) |=> irq);

  assert_deferred_reraises_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.rptDeferred |=> irq);

  assert_bus_reset_raise_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evBusRst && !cfgRptDis) |=> irq);

  assert_bus_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evBusRst && cfgRptDis && !irq && !anyRaise && !evCmpl) |=> !irq);

endmodule

bind intr_status_unit isu_checker #(.ADDR_W(ADDR_W)) i_isu_checker (
  .clk        (clk),
  .rstN       (rstN),
  .evFuncDone (evFuncDone),
  .evBusSvc   (evBusSvc),
  .evDisc     (evDisc),
  .evBusRst   (evBusRst),
  .evCmpl     (evCmpl),
  .busRd      (busRd),
  .busAddr    (busAddr),
  .irq        (irq),
  .cfgRptDis  (cfgRptDis),
  .strb       (strb)
);

// File: tb/test_intr_status_unit.sv
`timescale 1ns/1ps
module test_intr_status_unit;

  localparam logic [3:0] A_STAT = 4'd8, A_INTR = 4'd9, A_SEQ = 4'd10,
                         A_FLAGS = 4'd11, A_CFG = 4'd12, A_CSTAT = 4'd13;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evFuncDone = 0, evBusSvc = 0, evDisc = 0, evBusRst = 0, evCmpl = 0;
  logic [7:0] cmplStatus = '0;
  logic [3:0] busAddr = '0;
  logic       busWr = 0, busRd = 0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  intr_status_unit i_intr_status_unit (
    .clk(clk), .rstN(rstN),
    .evFuncDone(evFuncDone), .evBusSvc(evBusSvc), .evDisc(evDisc),
    .evBusRst(evBusRst), .evCmpl(evCmpl), .cmplStatus(cmplStatus),
    .busAddr(busAddr), .busWr(busWr), .busWrData(busWrData),
    .busRd(busRd), .busRdData(busRdData), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // one clock cycle of stimulus; read data sampled before the edge
  task automatic cyc(input logic rd, input logic [3:0] a, input logic wr,
                     input logic [7:0] wd, input logic fc, input logic bs,
                     input logic dc, input logic br, input logic cm,
                     input logic [7:0] cs, output logic [7:0] d);
    @(negedge clk);
    busRd = rd; busAddr = a; busWr = wr; busWrData = wd;
    evFuncDone = fc; evBusSvc = bs; evDisc = dc; evBusRst = br;
    evCmpl = cm; cmplStatus = cs;
    #1 d = busRdData;
    @(posedge clk);
    #1;
    busRd = 0; busWr = 0; evFuncDone = 0; evBusSvc = 0; evDisc = 0;
    evBusRst = 0; evCmpl = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    cyc(1, a, 0, 8'h00, 0, 0, 0, 0, 0, 8'h00, d);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    logic [7:0] dummy;
    cyc(0, a, 1, v, 0, 0, 0, 0, 0, 8'h00, dummy);
  endtask

  task automatic ev(input logic fc, input logic bs, input logic dc,
                    input logic br, input logic cm, input logic [7:0] cs);
    logic [7:0] dummy;
    cyc(0, 4'd0, 0, 8'h00, fc, bs, dc, br, cm, cs, dummy);
  endtask

  task automatic testReset();
    logic [7:0] d;
    chk("R9 irq", {7'd0, irq}, 8'h00);
    rd(A_STAT, d); chk("R9 status", d, 8'h00);
    rd(A_CFG, d);  chk("R9 cfg", d, 8'h07);
    rd(A_SEQ, d);  chk("R9 seq", d, 8'h00);
    rd(4'd1, d);   chk("R9 tc1", d, 8'h00);
    rd(A_INTR, d); chk("R9 intr", d, 8'h00);
  endtask

  task automatic testRaiseAck();
    logic [7:0] d;
    ev(1, 0, 0, 0, 0, 8'h00);
    chk("R1 irq after fc", {7'd0, irq}, 8'h01);
    rd(A_STAT, d); chk("R1 status pending", d, 8'h80);
    ev(1, 0, 0, 0, 0, 8'h00);
    ev(0, 1, 0, 0, 0, 8'h00);
    rd(A_INTR, d); chk("R2 read returns old causes", d, 8'h18);
    chk("R2 irq low", {7'd0, irq}, 8'h00);
    rd(A_INTR, d); chk("R2 causes cleared", d, 8'h00);
    rd(A_SEQ, d);  chk("R2 seq done step", d, 8'h04);
    rd(A_STAT, d); chk("R2 status cleared", d, 8'h00);
    ev(0, 0, 1, 0, 0, 8'h00);
    rd(A_SEQ, d);  chk("R1 disconnect seq", d, 8'h00);
    rd(A_INTR, d); chk("R1 disconnect cause", d, 8'h20);
  endtask

  task automatic testSameCycle();
    logic [7:0] d;
    ev(1, 0, 0, 0, 0, 8'h00);
    cyc(1, A_INTR, 0, 8'h00, 0, 1, 0, 0, 0, 8'h00, d);
    chk("R3 read returns old", d, 8'h08);
    chk("R3 irq kept", {7'd0, irq}, 8'h01);
    rd(A_INTR, d); chk("R3 only new cause", d, 8'h10);
    chk("R3 irq low after", {7'd0, irq}, 8'h00);
  endtask

  task automatic testImmediate();
    logic [7:0] d;
    wr(4'd0, 8'h11); wr(4'd1, 8'h22); wr(4'd2, 8'h33); wr(A_FLAGS, 8'h05);
    rd(4'd2, d); chk("R10 tc write", d, 8'h33);
    rd(A_FLAGS, d); chk("R10 flags write", d, 8'h05);
    ev(0, 0, 0, 0, 1, 8'h02);
    chk("R4 irq", {7'd0, irq}, 8'h01);
    rd(A_STAT, d);  chk("R4 status", d, 8'h93);
    rd(4'd0, d);    chk("R4 tc0", d, 8'h00);
    rd(4'd2, d);    chk("R4 tc2", d, 8'h00);
    rd(A_FLAGS, d); chk("R4 flags", d, 8'h00);
    rd(A_SEQ, d);   chk("R4 seq", d, 8'h00);
    rd(A_CSTAT, d); chk("R4 completion byte", d, 8'h02);
    wr(4'd1, 8'h01);
    rd(A_STAT, d);  chk("R10 tc write clears TC", d, 8'h83);
    rd(A_INTR, d);  chk("R4 cause", d, 8'h10);
    rd(A_STAT, d);  chk("R2 status after ack", d, 8'h03);
  endtask

  task automatic testDeferred();
    logic [7:0] d;
    ev(1, 0, 0, 0, 0, 8'h00);
    ev(0, 0, 0, 0, 1, 8'h01);
    ev(0, 0, 0, 0, 1, 8'h05);
    chk("R5 irq held", {7'd0, irq}, 8'h01);
    rd(A_STAT, d);  chk("R5 status untouched", d, 8'h83);
    rd(A_CSTAT, d); chk("R5 completion byte untouched", d, 8'h02);
    rd(A_INTR, d);  chk("R6 ack returns old", d, 8'h08);
    chk("R6 irq re-raised", {7'd0, irq}, 8'h01);
    rd(A_STAT, d);  chk("R6 status reported", d, 8'h93);
    rd(A_CSTAT, d); chk("R7 newest held byte", d, 8'h05);
    rd(A_INTR, d);  chk("R6 cause", d, 8'h10);
    chk("R6 held consumed", {7'd0, irq}, 8'h00);
    // fresh completion during the acknowledging read with nothing held
    ev(1, 0, 0, 0, 0, 8'h00);
    cyc(1, A_INTR, 0, 8'h00, 0, 0, 0, 0, 1, 8'h44, d);
    chk("R4 ack read old", d, 8'h08);
    rd(A_CSTAT, d); chk("R4 completion at ack", d, 8'h44);
    rd(A_INTR, d);  chk("R4 cause at ack", d, 8'h10);
  endtask

  task automatic testBusReset();
    logic [7:0] d;
    ev(0, 0, 0, 1, 0, 8'h00);
    chk("R8 irq raised", {7'd0, irq}, 8'h01);
    rd(A_INTR, d); chk("R8 cause", d, 8'h80);
    wr(A_CFG, 8'h47);
    rd(A_CFG, d);  chk("R10 cfg write", d, 8'h47);
    ev(0, 0, 0, 1, 0, 8'h00);
    chk("R8 irq suppressed", {7'd0, irq}, 8'h00);
    rd(A_INTR, d); chk("R8 cause without irq", d, 8'h80);
  endtask

  initial begin
    #501;
    if (rstN !== 1'b1 || checks == 0) begin end
  end

  initial begin : watchdog
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRaiseAck();
    testSameCycle();
    testImmediate();
    testDeferred();
    testBusReset();
    repeat (2) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule